// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This controller refills one eight-word cache line after a miss. Given the block address and the offset of the word that missed, it asks memory for that word before any other. It hands the word to the processor one cycle after it arrives, so the processor can resume while the rest of the line is still on its way. The other seven words are then requested in wrap-around order, starting just after the missed word and wrapping through word 0. Each word is written into the data array through a line-write port with one enable bit per word. Tag and valid are written only after all eight words are in place.

While the line is filling, the processor may read other words of the same line through a small read port. A read of a word that has already arrived is answered at once from a local copy of the line. A read of a word that has not arrived yet is held until that word comes in from memory. A new miss offered during a fill is refused: the busy output is high, and the request has no effect. The wrapped order helps most with long lines, since the processor usually wants the next sequential word soon after the missed one.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: One cycle after a miss is accepted (miss_valid high while miss_busy is low), mem_req_valid is high and mem_req_addr equals {miss_blk, miss_off}. The offset is in the low three bits.
- R2: Each accepted memory request is followed by one whose offset is the previous offset plus one, modulo 8, with the same block address.
- R3: A fill issues exactly eight memory requests. mem_req_valid is low from the cycle after the eighth handshake onward.
- R4: In the cycle after the first response beat of a fill, cpu_rsp_valid is high, cpu_rsp_off equals the missed offset, and cpu_rsp_data equals that beat's data.
- R5: In the cycle after each response beat, line_we has exactly one bit set, the bit for that beat's wrapped offset (bit i is word i). line_wdata is the beat data and line_blk is the block. line_we is zero in every other cycle.
- R6: tag_we pulses for exactly one cycle, with tag_blk equal to the block. The pulse comes in the cycle after the line write of the eighth word.
- R7: miss_busy is high from the cycle after acceptance until tag_we pulses, and it goes low in that same cycle. A miss presented while miss_busy is high changes neither the block nor the request sequence.
- R8: A processor read accepted (cpu_rd_valid and cpu_rd_ready) for a word that is already filled is answered in the next cycle with that word's offset and data.
- R9: A processor read accepted for a word not yet filled is answered in the cycle after that word's beat arrives. If the beat arrives at the same edge as the read, the answer comes in the next cycle.
- R10: cpu_rd_ready is low while idle, before the critical word has arrived, and while an earlier read is waiting for its word.
- R11: After reset, miss_busy, mem_req_valid, cpu_rd_ready, cpu_rsp_valid, line_we and tag_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_blk | input | BLK_W | Block address of the missing line |
| miss_off | input | OFF_W | Word offset that missed |
| miss_busy | output | 1 | Fill in progress; misses refused |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | BLK_W+OFF_W | Word address {block, offset} |
| mem_rsp_valid | input | 1 | Memory response beat, in request order |
| mem_rsp_data | input | DATA_W | Response data |
| cpu_rd_valid | input | 1 | Processor read of the refilling line |
| cpu_rd_off | input | OFF_W | Word offset of that read |
| cpu_rd_ready | output | 1 | Read can be taken this cycle |
| cpu_rsp_valid | output | 1 | Word returned to the processor |
| cpu_rsp_off | output | OFF_W | Offset of the returned word |
| cpu_rsp_data | output | DATA_W | Returned word |
| line_we | output | WORDS | Per-word write enable for the data array |
| line_wdata | output | DATA_W | Word written to the data array |
| line_blk | output | BLK_W | Block whose line is written |
| tag_we | output | 1 | Tag and valid write pulse |
| tag_blk | output | BLK_W | Block address stored in the tag |

## Verification
Every result here lands exactly one cycle after the edge that causes it, with one exception. The first request, each line write, the critical-word return, a hit on a filled word and the drop of busy all appear one cycle after their cause. The tag write comes two cycles after the final beat, and a waiting read is answered one cycle after its word's beat, however long that takes. The bench drives inputs on falling edges and samples on the next falling edge. There it attributes each output to the stimulus of the edge between, keeping its own record of which requests were accepted, which words have arrived and which read is waiting. Random ready, response and read patterns change when these events fall, but not their distance in cycles.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_FILL,
    FS_COMMIT
  } fill_state_e;

  // next word offset inside a line of n words, wrapping to zero
  function automatic int wrap_next(int off, int n);
    return (off + 1 >= n) ? 0 : off + 1;
  endfunction
endpackage

// File: rtl/cwf_req_gen.sv
module cwf_req_gen #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] start_off,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [OFF_W-1:0] req_off
);
  logic [CNT_W-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_off   <= '0;
      sent      <= '0;
    end else if (start) begin
      req_valid <= 1'b1;
      req_off   <= start_off;
      sent      <= '0;
    end else if (req_valid && req_ready) begin
      req_off <= OFF_W'(cwf_pkg::wrap_next(int'(req_off), WORDS));
      sent    <= sent + 1'b1;
      if (sent == CNT_W'(WORDS - 1)) req_valid <= 1'b0;
    end
  end

  // R2: accepted request is followed by the wrapped successor offset
  p_wrap_step_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !start |=> !req_valid ||
      (int'(req_off) == (int'($past(req_off)) + 1) % WORDS));

  // R3: never more requests than words in a line
  p_req_limit_r3: assert property (@(posedge clk) disable iff (rst)
    int'(sent) <= WORDS);
endmodule

// File: rtl/cwf_beat_track.sv
module cwf_beat_track #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] start_off,
  input  logic             beat,
  output logic [OFF_W-1:0] cur_off,
  output logic [WORDS-1:0] filled,
  output logic             crit_done,
  output logic             last_beat
);
  logic [CNT_W-1:0] got;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_off   <= '0;
      filled    <= '0;
      crit_done <= 1'b0;
      got       <= '0;
    end else if (start) begin
      cur_off   <= start_off;
      filled    <= '0;
      crit_done <= 1'b0;
      got       <= '0;
    end else if (beat) begin
      filled[cur_off] <= 1'b1;
      cur_off   <= OFF_W'(cwf_pkg::wrap_next(int'(cur_off), WORDS));
      crit_done <= 1'b1;
      got       <= got + 1'b1;
    end
  end

  assign last_beat = beat && (got == CNT_W'(WORDS - 1));

  // R5: every beat lands on a word not yet written in this fill
  p_fresh_word_r5: assert property (@(posedge clk) disable iff (rst)
    beat |-> !filled[cur_off]);
endmodule

// File: rtl/cwf_line_ram.sv
module cwf_line_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 24,
  localparam int OFF_W = $clog2(WORDS),
  localparam int AW    = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [BLK_W-1:0]  miss_blk,
  input  logic [OFF_W-1:0]  miss_off,
  output logic              miss_busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              cpu_rd_valid,
  input  logic [OFF_W-1:0]  cpu_rd_off,
  output logic              cpu_rd_ready,
  output logic              cpu_rsp_valid,
  output logic [OFF_W-1:0]  cpu_rsp_off,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic [WORDS-1:0]  line_we,
  output logic [DATA_W-1:0] line_wdata,
  output logic [BLK_W-1:0]  line_blk,
  output logic              tag_we,
  output logic [BLK_W-1:0]  tag_blk
);
  import cwf_pkg::*;

  fill_state_e       state;
  logic [BLK_W-1:0]  blk_r;
  logic              start, beat, last_beat, crit_done;
  logic [OFF_W-1:0]  req_off, cur_off;
  logic [WORDS-1:0]  filled;
  logic              pend_v;
  logic [OFF_W-1:0]  pend_off;
  logic              rsp_from_ram;
  logic [DATA_W-1:0] ram_q;
  logic              rd_acc, hit_now, hit_beat, pend_hit, crit_now;

  assign start        = (state == FS_IDLE) && miss_valid;
  assign beat         = (state == FS_FILL) && mem_rsp_valid;
  assign miss_busy    = (state != FS_IDLE);
  assign mem_req_addr = {blk_r, req_off};
  assign cpu_rd_ready = (state != FS_IDLE) && crit_done && !pend_v;

  assign rd_acc   = cpu_rd_valid && cpu_rd_ready;
  assign hit_now  = rd_acc && filled[cpu_rd_off];
  assign hit_beat = rd_acc && beat && (cur_off == cpu_rd_off);
  assign pend_hit = pend_v && beat && (cur_off == pend_off);
  assign crit_now = beat && !crit_done;

  cwf_req_gen #(.WORDS(WORDS)) u_req (
    .clk(clk), .rst(rst), .start(start), .start_off(miss_off),
    .req_ready(mem_req_ready), .req_valid(mem_req_valid), .req_off(req_off)
  );

  cwf_beat_track #(.WORDS(WORDS)) u_track (
    .clk(clk), .rst(rst), .start(start), .start_off(miss_off), .beat(beat),
    .cur_off(cur_off), .filled(filled), .crit_done(crit_done), .last_beat(last_beat)
  );

  cwf_line_ram #(.DEPTH(WORDS), .WIDTH(DATA_W)) u_copy (
    .clk(clk), .we(beat), .waddr(cur_off), .wdata(mem_rsp_data),
    .raddr(cpu_rd_off), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FS_IDLE;
      blk_r   <= '0;
      tag_we  <= 1'b0;
      tag_blk <= '0;
    end else begin
      tag_we <= 1'b0;
      case (state)
        FS_IDLE:   if (miss_valid) begin
                     state <= FS_FILL;
                     blk_r <= miss_blk;
                   end
        FS_FILL:   if (last_beat) state <= FS_COMMIT;
        FS_COMMIT: begin
                     state   <= FS_IDLE;
                     tag_we  <= 1'b1;
                     tag_blk <= blk_r;
                   end
        default:   state <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_we    <= '0;
      line_wdata <= '0;
      line_blk   <= '0;
    end else begin
      line_we <= beat ? (WORDS'(1) << cur_off) : '0;
      if (beat) begin
        line_wdata <= mem_rsp_data;
        line_blk   <= blk_r;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v        <= 1'b0;
      pend_off      <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_off   <= '0;
      rsp_from_ram  <= 1'b0;
    end else begin
      cpu_rsp_valid <= crit_now || hit_now || hit_beat || pend_hit;
      rsp_from_ram  <= hit_now;
      if (hit_now || hit_beat) cpu_rsp_off <= cpu_rd_off;
      else if (pend_hit)       cpu_rsp_off <= pend_off;
      else if (crit_now)       cpu_rsp_off <= cur_off;
      if (start) pend_v <= 1'b0;
      else if (rd_acc && !hit_now && !hit_beat) begin
        pend_v   <= 1'b1;
        pend_off <= cpu_rd_off;
      end else if (pend_hit) pend_v <= 1'b0;
    end
  end

  assign cpu_rsp_data = rsp_from_ram ? ram_q : line_wdata;

  // R1: first request carries the missed block and offset
  p_first_req_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> mem_req_valid && mem_req_addr == {$past(miss_blk), $past(miss_off)});

  // R4: critical word returned the cycle after it arrives
  p_crit_return_r4: assert property (@(posedge clk) disable iff (rst)
    crit_now |=> cpu_rsp_valid && cpu_rsp_data == $past(mem_rsp_data));

  // R5: one word enable per beat
  p_one_enable_r5: assert property (@(posedge clk) disable iff (rst)
    beat |=> $countones(line_we) == 1);

  // R6: tag written only with the whole line present
  p_tag_full_r6: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> &filled);

  // R7: a refused miss leaves the block untouched
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    miss_busy && miss_valid |=> $stable(blk_r));

  // R8: read of a filled word answered next cycle
  p_hit_filled_r8: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> cpu_rsp_valid && cpu_rsp_off == $past(cpu_rd_off));

  // R10: reads refused before the critical word
  p_ready_gate_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_ready |-> crit_done && $onehot0(line_we));
endmodule

// File: tb/cwf_fill_ctrl_bench.sv
module cwf_fill_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 8;
  localparam int DATA_W = 32;
  localparam int BLK_W  = 24;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int AW     = BLK_W + OFF_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              miss_valid;
  logic [BLK_W-1:0]  miss_blk;
  logic [OFF_W-1:0]  miss_off;
  logic              miss_busy;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [AW-1:0]     mem_req_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;
  logic              cpu_rd_valid;
  logic [OFF_W-1:0]  cpu_rd_off;
  logic              cpu_rd_ready;
  logic              cpu_rsp_valid;
  logic [OFF_W-1:0]  cpu_rsp_off;
  logic [DATA_W-1:0] cpu_rsp_data;
  logic [WORDS-1:0]  line_we;
  logic [DATA_W-1:0] line_wdata;
  logic [BLK_W-1:0]  line_blk;
  logic              tag_we;
  logic [BLK_W-1:0]  tag_blk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cwf_fill_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_cwf_fill_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_off(miss_off), .miss_busy(miss_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cpu_rd_valid(cpu_rd_valid), .cpu_rd_off(cpu_rd_off), .cpu_rd_ready(cpu_rd_ready),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_off(cpu_rsp_off), .cpu_rsp_data(cpu_rsp_data),
    .line_we(line_we), .line_wdata(line_wdata), .line_blk(line_blk),
    .tag_we(tag_we), .tag_blk(tag_blk)
  );

  function automatic logic [DATA_W-1:0] word_val(logic [BLK_W-1:0] b, int o);
    return DATA_W'((32'(b) * 32'h9E3779B1) ^ (32'(o + 1) * 32'h01000193) ^ 32'h5A5A0000);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    miss_valid = 1'b0; miss_blk = '0; miss_off = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    cpu_rd_valid = 1'b0; cpu_rd_off = '0;
  endtask

  task automatic do_fill(logic [BLK_W-1:0] blk, int off, int rdy_pct, int vld_pct,
                         int rd_pct, bit busy_miss);
    int q[WORDS];
    int qh = 0, qt = 0, nreq = 0, nbeat = 0, beat_off, rd_o = 0, pend_off = 0;
    bit pend = 0, drove_ready = 0, drove_rsp = 0, drove_rd = 0, prev_rd_ready = 0;
    bit prev_req_v, tag_due = 0, done = 0, exp_rsp;
    logic [AW-1:0] prev_addr;
    int exp_off;

    @(negedge clk);
    miss_valid = 1'b1; miss_blk = blk; miss_off = OFF_W'(off);
    @(negedge clk);
    miss_valid = 1'b0;
    check(miss_busy == 1'b1, "R7 busy after accept", miss_busy, 1);
    check(mem_req_valid && mem_req_addr == {blk, OFF_W'(off)}, "R1 first request",
          mem_req_addr, {blk, OFF_W'(off)});
    prev_req_v = mem_req_valid; prev_addr = mem_req_addr;
    for (int it = 0; it < 2000 && !done; it++) begin
      // drive this cycle's inputs
      check(!(cpu_rd_ready && (nbeat == 0 || pend)), "R10 ready gate", cpu_rd_ready, 0);
      prev_rd_ready = cpu_rd_ready;
      drove_ready = ($urandom % 100) < rdy_pct;
      mem_req_ready = drove_ready;
      drove_rsp = (qt > qh) && (($urandom % 100) < vld_pct);
      mem_rsp_valid = drove_rsp;
      mem_rsp_data = drove_rsp ? word_val(blk, q[qh]) : '0;
      drove_rd = ($urandom % 100) < rd_pct;
      rd_o = int'($urandom % WORDS);
      cpu_rd_valid = drove_rd; cpu_rd_off = OFF_W'(rd_o);
      if (busy_miss && it == 2) begin
        miss_valid = 1'b1; miss_blk = ~blk; miss_off = OFF_W'(off + 3);
      end else miss_valid = 1'b0;
      @(negedge clk);
      // beat effects
      beat_off = -1;
      if (drove_rsp) begin
        beat_off = q[qh]; qh++; nbeat++;
        check(line_we == (WORDS'(1) << beat_off) && line_wdata == word_val(blk, beat_off)
              && line_blk == blk, "R5 line write", line_we, WORDS'(1) << beat_off);
      end else check(line_we == '0, "R5 no write", line_we, 0);
      // processor responses
      exp_rsp = 0; exp_off = 0;
      if (drove_rsp && nbeat == 1) begin
        exp_rsp = 1; exp_off = beat_off;
        check(cpu_rsp_valid && int'(cpu_rsp_off) == off && cpu_rsp_data == word_val(blk, off),
              "R4 critical word", cpu_rsp_off, off);
      end else if (drove_rd && prev_rd_ready) begin
        if (q_has(beat_off, rd_o, q, qh, nbeat) || beat_off == rd_o) begin
          exp_rsp = 1; exp_off = rd_o;
          check(cpu_rsp_valid && int'(cpu_rsp_off) == rd_o && cpu_rsp_data == word_val(blk, rd_o),
                (beat_off == rd_o) ? "R9 same-edge read" : "R8 filled read", cpu_rsp_data,
                word_val(blk, rd_o));
        end else begin
          pend = 1; pend_off = rd_o;
        end
      end else if (pend && beat_off == pend_off) begin
        exp_rsp = 1; pend = 0;
        check(cpu_rsp_valid && int'(cpu_rsp_off) == pend_off
              && cpu_rsp_data == word_val(blk, pend_off), "R9 waited read", cpu_rsp_off, pend_off);
      end
      if (!exp_rsp) check(!cpu_rsp_valid, "R8 no spurious response", cpu_rsp_valid, 0);
      // request handshake
      if (prev_req_v && drove_ready) begin
        check(prev_addr == {blk, OFF_W'((off + nreq) % WORDS)}, "R2 wrapped request",
              prev_addr, {blk, OFF_W'((off + nreq) % WORDS)});
        q[qt] = (off + nreq) % WORDS; qt++; nreq++;
        if (nreq == WORDS) check(!mem_req_valid, "R3 requests stop", mem_req_valid, 0);
      end
      // tag and busy
      if (tag_due) begin
        check(tag_we && tag_blk == blk && !miss_busy, "R6 tag write", tag_blk, blk);
        done = 1;
      end else begin
        check(!tag_we && miss_busy, "R7 busy during fill", miss_busy, 1);
        if (drove_rsp && nbeat == WORDS) tag_due = 1;
      end
      prev_req_v = mem_req_valid; prev_addr = mem_req_addr;
    end
    if (!done) check(0, "R6 fill never completed", 0, 1);
    idle_inputs();
    @(negedge clk);
    check(!tag_we && !cpu_rd_ready && !miss_busy, "R10 idle after fill", cpu_rd_ready, 0);
  endtask

  // true when word o has already arrived before this cycle's beat
  function automatic bit q_has(int cur_beat, int o, int q[WORDS], int qh, int nbeat);
    int upto = (cur_beat >= 0) ? qh - 1 : qh;
    for (int i = 0; i < upto; i++) if (q[i] == o) return 1;
    return 0;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!miss_busy && !mem_req_valid && !cpu_rd_ready && !cpu_rsp_valid
          && line_we == '0 && !tag_we, "R11 reset state", miss_busy, 0);
    // directed corners
    do_fill(24'h000010, 0, 100, 100, 0, 0);
    do_fill(24'h0ABCDE, 7, 100, 100, 60, 0);
    do_fill(24'h123456, 3, 50, 40, 80, 1);
    do_fill(24'hFFFFFF, 5, 30, 20, 90, 1);
    // random mixes
    for (int n = 0; n < 24; n++)
      do_fill(BLK_W'($urandom), int'($urandom % WORDS), 20 + int'($urandom % 81),
              20 + int'($urandom % 81), int'($urandom % 100), bit'($urandom % 2));
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule